// File: doc/BRIEF.md
# Synchronous Glitch-Free Clock Stop

This block gates a bank of shared output clocks and a dedicated free-running output from one 33 MHz source, under an active-low stop request. The stop request is sampled on a rising edge of the 33 MHz source and takes effect only at a following falling edge. A stopped output therefore finishes its high phase, parks low and later resumes with a full high phase. It never emits a shortened pulse.

Each shared lane has three configuration bits: an enable, a free-running exemption and a rate flag. When the rate flag is set, the lane carries the 66 MHz source instead of the 33 MHz one, and the stop request does not touch it. Lane configuration is taken in only while both sources are low, so changing it cannot cut a phase short.

One dual-purpose pin is decided by a strap captured while reset is held. In one setting the pin is the stop input. In the other it is an extra gated 33 MHz clock output, and stop control is off. All logic runs on a fast system clock. The two source clocks arrive as level inputs synchronous to it, and every output is a flop.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst` is high, every output is low and the stop state is released. The first stop request after reset is honoured only through the sampling in R2.
- R2: When the pin is in stop mode, `stop_n_i` is sampled at each rising edge of `src33_i`. A sampled 0 stops each affected lane at the next falling edge of `src33_i`, and the lane stays low. An affected lane is one that is enabled, has no free-running bit and has no rate flag. Its current high phase completes in full.
- R3: A sampled 1 on `stop_n_i` takes effect at the next falling edge of `src33_i`. Stopped lanes then resume at the following rising edge of `src33_i`, starting with a full high phase.
- R4: `free_clk_o` always follows `src33_i`, whatever the stop request, the strap and the lane configuration.
- R5: A lane with its rate flag set (`lane_fast_i[i]`=1) and its enable set follows `src66_i` and is never stopped.
- R6: A lane with its free-running bit set (`lane_frun_i[i]`=1) and its enable set follows `src33_i` while the other lanes are stopped.
- R7: A lane whose enable bit is 0 drives 0.
- R8: The lane and dual-pin configuration inputs are captured only in cycles where `src33_i` and `src66_i` are both low. A change made during a high phase of either source leaves that phase intact.
- R9: `strap_i` is captured while `rst` is high and held until the next reset. Strap 1 makes `stop_n_i` the stop input and holds `dual_clk_o` low. Strap 0 ignores `stop_n_i`, and `dual_clk_o` follows `src33_i` when `dual_en_i` is set.
- R10: Every clock output shows the value its source had in the previous system clock cycle, which is a one-cycle registered latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| strap_i | input | 1 | Pin-function strap: 1 = stop input, 0 = clock output |
| stop_n_i | input | 1 | Active-low stop request |
| src33_i | input | 1 | 33 MHz source level |
| src66_i | input | 1 | 66 MHz source level, rising together with `src33_i` |
| lane_en_i | input | N_LANES | Per-lane enable |
| lane_frun_i | input | N_LANES | Per-lane free-running exemption |
| lane_fast_i | input | N_LANES | Per-lane rate flag: 1 = 66 MHz, exempt from stop |
| dual_en_i | input | 1 | Enable for the dual-pin clock output |
| lane_clk_o | output | N_LANES | Gated lane clocks |
| free_clk_o | output | 1 | Free-running 33 MHz output |
| dual_clk_o | output | 1 | Clock output of the dual-purpose pin |

## Verification
The bench drops the stop request at phases away from the source edges. A design that applied the request at once, or at the rising edge, would clip a high phase to a runt, and the cycle-exact expected stream would catch that. The bench releases the request and checks that lanes restart on a rising edge with four full high cycles, where an early restart would show a short pulse. It runs lanes flagged for 66 MHz and lanes flagged free-running through a stop. A design that gated them would drop their edges. It also toggles a lane enable inside a high phase and checks that the change waits for the common low window. Finally it resets with the strap low and asserts stop, and the outputs must keep running.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef struct packed {
        logic en;
        logic frun;
        logic fast;
    } lane_cfg_t;

    localparam lane_cfg_t LANE_OFF = '{en: 1'b0, frun: 1'b0, fast: 1'b0};

    typedef enum logic {
        PIN_IS_CLOCK = 1'b0,
        PIN_IS_STOP  = 1'b1
    } dual_mode_t;

    // Level a lane drives for the given config, source levels and run state.
    function automatic logic lane_level(lane_cfg_t c, logic s33, logic s66, logic run);
        logic lvl;
        if (!c.en)
            lvl = 1'b0;
        else if (c.fast)
            lvl = s66;
        else
            lvl = s33 & (c.frun | run);
        return lvl;
    endfunction

endpackage

// File: rtl/csg_src_track.sv
module csg_src_track (
    input  logic clk,
    input  logic src33_i,
    input  logic src66_i,
    output logic s33_q,
    output logic rise33_o,
    output logic fall33_o,
    output logic quiet_o
);
    always_ff @(posedge clk) begin
        s33_q <= src33_i;
    end

    assign rise33_o = src33_i & ~s33_q;
    assign fall33_o = ~src33_i & s33_q;
    assign quiet_o  = ~src33_i & ~src66_i;
endmodule

// File: rtl/csg_stop_ctl.sv
module csg_stop_ctl
    import csg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_i,
    input  logic       stop_n_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       s33_q_i,
    output dual_mode_t mode_o,
    output logic       run_o
);
    dual_mode_t mode_q;
    logic       samp_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= dual_mode_t'(strap_i);
            samp_q <= 1'b1;
            run_q  <= 1'b1;
        end else begin
            if (rise_i)
                samp_q <= (mode_q == PIN_IS_STOP) ? stop_n_i : 1'b1;
            if (fall_i)
                run_q <= samp_q;
        end
    end

    assign mode_o = mode_q;
    assign run_o  = run_q;

    AST_RUN_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(run_q) |-> !s33_q_i); // R2
    AST_CLOCK_MODE_RUNS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PIN_IS_CLOCK) |-> run_q); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q)); // R9
endmodule

// File: rtl/csg_lane.sv
module csg_lane
    import csg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      quiet_i,
    input  lane_cfg_t cfg_i,
    input  logic      src33_i,
    input  logic      src66_i,
    input  logic      run_i,
    output logic      clk_o
);
    lane_cfg_t cfg_q;
    logic      out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= LANE_OFF;
            out_q <= 1'b0;
        end else begin
            out_q <= lane_level(cfg_q, src33_i, src66_i, run_i);
            if (quiet_i)
                cfg_q <= cfg_i;
        end
    end

    assign clk_o = out_q;

    AST_LANE_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> !clk_o); // R7
    AST_LANE_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (!run_i && cfg_q.en && !cfg_q.frun && !cfg_q.fast) |=> !clk_o); // R2
    AST_LANE_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> (!$past(src33_i) && !$past(src66_i))); // R8
    AST_LANE_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_q.fast) |=> (clk_o == $past(src66_i))); // R5
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import csg_pkg::*;
#(
    parameter int N_LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_i,
    input  logic               stop_n_i,
    input  logic               src33_i,
    input  logic               src66_i,
    input  logic [N_LANES-1:0] lane_en_i,
    input  logic [N_LANES-1:0] lane_frun_i,
    input  logic [N_LANES-1:0] lane_fast_i,
    input  logic               dual_en_i,
    output logic [N_LANES-1:0] lane_clk_o,
    output logic               free_clk_o,
    output logic               dual_clk_o
);
    localparam int LAST_LANE = N_LANES - 1;

    logic       s33_q;
    logic       rise33;
    logic       fall33;
    logic       quiet;
    logic       run;
    dual_mode_t mode;
    logic       dual_en_q;
    logic       free_q;
    logic       dual_q;

    csg_src_track u_track (
        .clk      (clk),
        .src33_i  (src33_i),
        .src66_i  (src66_i),
        .s33_q    (s33_q),
        .rise33_o (rise33),
        .fall33_o (fall33),
        .quiet_o  (quiet)
    );

    csg_stop_ctl u_stop (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap_i),
        .stop_n_i (stop_n_i),
        .rise_i   (rise33),
        .fall_i   (fall33),
        .s33_q_i  (s33_q),
        .mode_o   (mode),
        .run_o    (run)
    );

    for (genvar g = 0; g <= LAST_LANE; g++) begin : g_lane
        lane_cfg_t cfg;
        assign cfg = '{en: lane_en_i[g], frun: lane_frun_i[g], fast: lane_fast_i[g]};
        csg_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .quiet_i (quiet),
            .cfg_i   (cfg),
            .src33_i (src33_i),
            .src66_i (src66_i),
            .run_i   (run),
            .clk_o   (lane_clk_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dual_en_q <= 1'b0;
            free_q    <= 1'b0;
            dual_q    <= 1'b0;
        end else begin
            free_q <= src33_i;
            dual_q <= (mode == PIN_IS_CLOCK) & dual_en_q & src33_i;
            if (quiet)
                dual_en_q <= dual_en_i;
        end
    end

    assign free_clk_o = free_q;
    assign dual_clk_o = dual_q;

    AST_FREE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (free_clk_o == $past(src33_i))); // R4
    AST_DUAL_LOW_IN_STOP_MODE: assert property (@(posedge clk) disable iff (rst)
        (mode == PIN_IS_STOP) |=> !dual_clk_o); // R9
endmodule

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
    localparam int N = 4;
    localparam time CLK_PERIOD = 10;

    typedef struct packed {
        logic [N-1:0] lanes;
        logic         free;
        logic         dual;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strap = 1'b1;
    logic         stop_n = 1'b1;
    logic [2:0]   ph = 3'd0;
    logic         src33;
    logic         src66;
    logic [N-1:0] en = '0;
    logic [N-1:0] frun = '0;
    logic [N-1:0] fast = '0;
    logic         den = 1'b0;
    logic [N-1:0] lane_clk;
    logic         free_clk;
    logic         dual_clk;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;
    string tag = "R1";
    exp_t  exp_q[$];

    // Model state
    logic         m_strap, m_samp, m_run, m_den;
    logic [N-1:0] m_en, m_fr, m_fa;

    assign src33 = (ph < 3'd4);
    assign src66 = ~ph[1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) ph <= ph + 3'd1;

    clk_stop_gate #(.N_LANES(N)) i_clk_stop_gate (
        .clk         (clk),
        .rst         (rst),
        .strap_i     (strap),
        .stop_n_i    (stop_n),
        .src33_i     (src33),
        .src66_i     (src66),
        .lane_en_i   (en),
        .lane_frun_i (frun),
        .lane_fast_i (fast),
        .dual_en_i   (den),
        .lane_clk_o  (lane_clk),
        .free_clk_o  (free_clk),
        .dual_clk_o  (dual_clk)
    );

    // Expected-value generator, written from the requirements.
    always @(posedge clk) begin
        exp_t e;
        e = '0;
        if (rst) begin
            m_strap = strap; m_samp = 1'b1; m_run = 1'b1;
            m_en = '0; m_fr = '0; m_fa = '0; m_den = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_en[i])
                    e.lanes[i] = m_fa[i] ? src66 : (src33 & (m_fr[i] | m_run));
            end
            e.free = src33;
            e.dual = !m_strap & m_den & src33;
            if (!src33 && !src66) begin
                m_en = en; m_fr = frun; m_fa = fast; m_den = den;
            end
            if (ph == 3'd0) m_samp = m_strap ? stop_n : 1'b1;
            if (ph == 3'd4) m_run = m_samp;
        end
        exp_q.push_back(e);
    end

    // Monitor: pops and compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            exp_t a;
            e = exp_q.pop_front();
            a = '{lanes: lane_clk, free: free_clk, dual: dual_clk};
            compared++;
            if (a !== e) begin
                mismatched++;
                $display("FAIL %s: lanes/free/dual actual %b/%b/%b expected %b/%b/%b at %0t",
                         tag, a.lanes, a.free, a.dual, e.lanes, e.free, e.dual, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic to_phase(input logic [2:0] p);
        do step(1); while (ph != p);
    endtask

    initial begin
        // R1: reset state with strap = 1 (stop mode)
        tag = "R1";
        step(5);
        rst = 1'b0;
        // R7: lanes disabled stay low; R4 free output runs
        tag = "R7 R4 R10";
        step(16);
        // R8/R10: enable all lanes, change lands only in the common low window
        tag = "R8 R10";
        to_phase(3'd1);
        en = '1;
        step(24);
        // R2: stop requested mid high phase
        tag = "R2";
        to_phase(3'd2);
        stop_n = 1'b0;
        step(32);
        // R3: release, full high phase on restart
        tag = "R3";
        to_phase(3'd5);
        stop_n = 1'b1;
        step(32);
        // R5/R6: fast lane and free-running lane survive a stop
        tag = "R5 R6";
        fast = 4'b0001;
        frun = 4'b0010;
        step(8);
        to_phase(3'd7);
        stop_n = 1'b0;
        step(32);
        stop_n = 1'b1;
        step(24);
        // R8: enable toggled inside high phases
        tag = "R8";
        fast = '0; frun = '0;
        to_phase(3'd1);
        en[2] = 1'b0;
        to_phase(3'd5);
        en[2] = 1'b1;
        step(24);
        // R9: stop mode keeps the dual pin low even when enabled
        tag = "R9";
        den = 1'b1;
        step(24);
        // R9: reset with strap = 0, stop input ignored, dual pin clocks
        rst = 1'b1;
        strap = 1'b0;
        tag = "R1 R9";
        step(4);
        rst = 1'b0;
        strap = 1'b1;
        tag = "R9";
        step(16);
        stop_n = 1'b0;
        step(32);
        stop_n = 1'b1;
        step(8);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule